// File: doc/BRIEF.md
# UART FIFO threshold interrupt controller

This block sits next to the serial side of a UART. It holds a receive byte FIFO and a transmit byte FIFO, tracks how full each one is, and drives three interrupt lines: receive threshold, transmit threshold and transmitter empty. A single control byte sets the FIFO size, the two threshold codes and the FIFO enable, and it can empty either FIFO. A simple shift-out model drains the transmit FIFO onto a serial line, one bit per bit-clock tick. The receive threshold interrupt also fires when data has waited below the threshold for a programmable number of character times with no activity.

Bytes move on three valid/ready streams. On the receive input, the deserializer stream, a byte is taken only in a cycle with both valid and ready high. Ready is low while the receive FIFO is at its current capacity, and the source must hold its byte until ready returns. The receive output is the host read path: valid is high whenever the FIFO holds data, and a byte leaves in a cycle where ready is also high. The transmit input is the host write path and follows the same rules as the receive input.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset the control byte is all zero, both FIFOs are empty, `irq_rx_thr` and `irq_tx_empty` are 0, `irq_tx_thr` is 1, and `txd` is 1.
- R2: Control bit 0 enables the FIFOs and bit 3 selects the 32-byte size (0 selects 16 bytes). With bit 0 clear, each FIFO holds a single byte. An input's ready is low exactly when its FIFO holds its current capacity.
- R3: `irq_rx_thr` is 1 whenever the receive count is at or above the receive threshold. The threshold is picked by control bits 7:6: codes 0,1,2,3 give 1,4,8,14 bytes at the 16-byte size and 1,4,16,26 bytes at the 32-byte size.
- R4: Once host reads bring the receive count below the threshold, `irq_rx_thr` drops in the cycle after the read.
- R5: The receive FIFO can hold data below the threshold with no receive write and no host read for TOUT_CHARS*CHAR_TICKS bit ticks (40 by default). When that happens, `irq_rx_thr` is set and held until a host read or a receive flush. Any receive write or host read restarts the count.
- R6: `irq_tx_thr` is 1 while the transmit FIFO count is below the transmit threshold. Control bits 5:4 select that threshold with the same code table as R3.
- R7: `irq_tx_empty` is set one cycle after the transmit FIFO and the shifter both become empty. It clears in the cycle after `isr_rd` is pulsed. A new set wins over a read in the same cycle.
- R8: Writing the control byte with bit 1 set empties the receive FIFO, and with bit 2 set empties the transmit FIFO, in the cycle after the write. These bits act once and are not held.
- R9: Bytes leave each FIFO in arrival order. A receive input offered while ready is low is not stored.
- R10: The shifter takes a byte from the transmit FIFO when idle. It sends a 10-bit frame on `txd`, one bit per `bit_tick`: a 0 start bit, then the data LSB first, then a 1 stop bit. It then stays busy for one more tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: 7:6 rx code, 5:4 tx code, 3 size, 2 tx flush, 1 rx flush, 0 enable |
| isr_rd | input | 1 | Interrupt status read strobe |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_in_valid | input | 1 | Receive byte offered |
| rx_in_ready | output | 1 | Receive FIFO has room |
| rx_in_data | input | DW | Receive byte |
| rx_out_valid | output | 1 | Receive FIFO holds data |
| rx_out_ready | input | 1 | Host takes a byte |
| rx_out_data | output | DW | Oldest receive byte |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit FIFO has room |
| tx_in_data | input | DW | Transmit byte |
| txd | output | 1 | Serial output, idle high |
| irq_rx_thr | output | 1 | Receive threshold or timeout interrupt |
| irq_tx_thr | output | 1 | Transmit level below threshold |
| irq_tx_empty | output | 1 | Transmitter went empty, sticky |

## Verification
The receive threshold is exercised at one byte below and exactly at each tested code, at both sizes. This separates the 16-byte table from the 32-byte one, and also catches a code change made with data already held. The timeout is probed one tick short of the limit and at the limit, and then again after a host read and after a receive write, which shows whether each one restarts the count. The transmit side is driven with a burst that crosses the threshold while the shifter drains a known frame. A flush then shows that the empty interrupt waits for the shifter and is cleared by a status read and not by the passage of time.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       big;
    logic       en;
  } ufq_cfg_t;

  // threshold in bytes for a code, at the small or large FIFO size
  function automatic int unsigned thr_bytes(input logic [1:0] code, input logic big);
    case (code)
      2'd0:    thr_bytes = 1;
      2'd1:    thr_bytes = 4;
      2'd2:    thr_bytes = big ? 16 : 8;
      default: thr_bytes = big ? 26 : 14;
    endcase
  endfunction

endpackage

// File: rtl/ufq_fifo.sv
// Byte FIFO with run-time capacity; DEPTH must be a power of two.
module ufq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = count < cap;
  assign out_valid = count != '0;
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ufq_rx_timer.sv
// Counts bit ticks while armed; fires once at LIMIT until cleared.
module ufq_rx_timer #(
  parameter int LIMIT = 40,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic restart,
  input  logic clear,
  output logic fired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (clear) fired <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (armed && tick && !fired) begin
        if (cnt == CW'(LIMIT - 1)) begin
          fired <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ufq_tx_shift.sv
// Start bit, DW data bits LSB first, stop bit; one bit per tick.
module ufq_tx_shift #(
  parameter int DW    = 8,
  localparam int FW   = DW + 2,
  localparam int LW   = $clog2(FW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [DW-1:0] ld_data,
  output logic          busy,
  output logic          txd
);
  logic [FW-1:0] sh;
  logic [LW-1:0] left;

  assign ld_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (ld_valid && !busy) begin
      sh   <= {1'b1, ld_data, 1'b0};
      left <= LW'(FW + 1);
      busy <= 1'b1;
    end else if (busy && tick) begin
      txd  <= sh[0];
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - 1'b1;
      if (left == LW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MAX_DEPTH  = 32,
  parameter int CHAR_TICKS = 10,
  parameter int TOUT_CHARS = 4,
  localparam int LW        = $clog2(MAX_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  input  logic          isr_rd,
  input  logic          bit_tick,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          txd,
  output logic          irq_rx_thr,
  output logic          irq_tx_thr,
  output logic          irq_tx_empty
);
  ufq_cfg_t      cfg;
  logic          rx_flush, tx_flush;
  logic [LW-1:0] cap, rx_cnt, tx_cnt, rx_thr, tx_thr;
  logic          sh_valid, sh_ready, tx_busy;
  logic [DW-1:0] sh_data;
  logic          rx_wr, rx_rd, tout;
  logic          tx_idle, idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      rx_flush <= cfg_wr && cfg_wdata[1];
      tx_flush <= cfg_wr && cfg_wdata[2];
      if (cfg_wr) cfg <= '{rx_code: cfg_wdata[7:6], tx_code: cfg_wdata[5:4],
                           big: cfg_wdata[3], en: cfg_wdata[0]};
    end
  end

  assign cap    = !cfg.en ? LW'(1) : (cfg.big ? LW'(MAX_DEPTH) : LW'(MAX_DEPTH / 2));
  assign rx_thr = LW'(thr_bytes(cfg.rx_code, cfg.big));
  assign tx_thr = LW'(thr_bytes(cfg.tx_code, cfg.big));

  ufq_fifo #(.DW(DW), .DEPTH(MAX_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(rx_flush), .cap,
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_cnt));

  ufq_fifo #(.DW(DW), .DEPTH(MAX_DEPTH)) u_txq (
    .clk, .rst_n, .flush(tx_flush), .cap,
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(sh_valid), .out_ready(sh_ready), .out_data(sh_data),
    .count(tx_cnt));

  ufq_tx_shift #(.DW(DW)) u_shift (
    .clk, .rst_n, .tick(bit_tick),
    .ld_valid(sh_valid && !tx_flush), .ld_ready(sh_ready), .ld_data(sh_data),
    .busy(tx_busy), .txd);

  assign rx_wr = rx_in_valid && rx_in_ready && !rx_flush;
  assign rx_rd = rx_out_valid && rx_out_ready && !rx_flush;

  ufq_rx_timer #(.LIMIT(TOUT_CHARS * CHAR_TICKS)) u_tout (
    .clk, .rst_n, .tick(bit_tick),
    .armed(rx_cnt != '0 && rx_cnt < rx_thr),
    .restart(rx_wr || rx_rd || rx_flush),
    .clear(rx_rd || rx_flush),
    .fired(tout));

  assign irq_rx_thr = (rx_cnt >= rx_thr) || tout;
  assign irq_tx_thr = tx_cnt < tx_thr;

  assign tx_idle = (tx_cnt == '0) && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q       <= 1'b1;
      irq_tx_empty <= 1'b0;
    end else begin
      idle_q <= tx_idle;
      if (tx_idle && !idle_q) irq_tx_empty <= 1'b1;
      else if (isr_rd)        irq_tx_empty <= 1'b0;
    end
  end
endmodule

// File: rtl/ufq_checker.sv
module ufq_checker #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          isr_rd,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          rx_flush,
  input logic [LW-1:0] rx_cnt,
  input logic [LW-1:0] tx_cnt,
  input logic          tx_busy,
  input logic          txd,
  input logic          irq_rx_thr,
  input logic          irq_tx_empty
);
  // R9: the receive level moves by at most one byte per cycle except on flush
  a_r9_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_flush) |-> (rx_cnt == $past(rx_cnt)) || (rx_cnt == $past(rx_cnt) + 1)
                         || (rx_cnt + 1 == $past(rx_cnt)));

  // R4: the receive interrupt only drops after a read, a flush or a control write
  a_r4_rx_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_rx_thr) |-> $past(rx_out_valid && rx_out_ready) || $past(rx_flush) || $past(cfg_wr));

  // R5: the receive interrupt never stands with an empty receive FIFO
  a_r5_rx_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_thr |-> rx_cnt != '0);

  // R7: the empty flag is cleared only by a status read
  a_r7_empty_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx_empty) |-> $past(isr_rd));

  // R7: the empty flag rises only after the transmit path was idle
  a_r7_empty_set_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx_empty) |-> $past(tx_cnt == '0 && !tx_busy));

  // R10: the serial line rests high whenever the shifter is idle
  a_r10_txd_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind uart_fifo_irq_ctrl ufq_checker #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .isr_rd(isr_rd),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_flush(rx_flush),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .tx_busy(tx_busy), .txd(txd),
  .irq_rx_thr(irq_rx_thr), .irq_tx_empty(irq_tx_empty));

// File: tb/sim_uart_fifo_irq_ctrl.sv
module sim_uart_fifo_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       cfg_wr = 0, isr_rd = 0, bit_tick = 0;
  logic [7:0] cfg_wdata = 0;
  logic       rx_in_valid = 0, rx_out_ready = 0, tx_in_valid = 0;
  logic [7:0] rx_in_data = 0, tx_in_data = 0;
  logic       rx_in_ready, rx_out_valid, tx_in_ready, txd;
  logic [7:0] rx_out_data;
  logic       irq_rx_thr, irq_tx_thr, irq_tx_empty;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_irq_ctrl u0 (
    .clk, .rst_n, .cfg_wr, .cfg_wdata, .isr_rd, .bit_tick,
    .rx_in_valid, .rx_in_ready, .rx_in_data,
    .rx_out_valid, .rx_out_ready, .rx_out_data,
    .tx_in_valid, .tx_in_ready, .tx_in_data,
    .txd, .irq_rx_thr, .irq_tx_thr, .irq_tx_empty);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic cfg(input logic [7:0] w);
    cfg_wr = 1; cfg_wdata = w; cyc(1); cfg_wr = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d; cyc(1); rx_in_valid = 0;
  endtask

  task automatic rx_pop(output logic [7:0] d);
    rx_out_ready = 1; d = rx_out_data; cyc(1); rx_out_ready = 0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d; cyc(1); tx_in_valid = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cyc(1); bit_tick = 0; end
  endtask

  task automatic t_reset;
    chk("R1 irq_rx_thr", irq_rx_thr, 0);
    chk("R1 irq_tx_thr", irq_tx_thr, 1);
    chk("R1 irq_tx_empty", irq_tx_empty, 0);
    chk("R1 txd", txd, 1);
    chk("R1 rx_out_valid", rx_out_valid, 0);
  endtask

  task automatic t_depth1;
    logic [7:0] d;
    rx_push(8'h3C);
    chk("R2 depth1 ready low", rx_in_ready, 0);
    chk("R3 code0 thr1", irq_rx_thr, 1);
    rx_push(8'h77);
    rx_pop(d);
    chk("R9 depth1 data", d, 8'h3C);
    chk("R9 blocked byte not stored", rx_out_valid, 0);
    chk("R4 irq drops after read", irq_rx_thr, 0);
  endtask

  task automatic t_rx16;
    logic [7:0] d;
    cfg(8'b0100_0001);
    for (int i = 0; i < 3; i++) rx_push(8'(i));
    chk("R3 16 code1 at 3", irq_rx_thr, 0);
    rx_push(8'd3);
    chk("R3 16 code1 at 4", irq_rx_thr, 1);
    cfg(8'b1100_0011); cyc(1);
    chk("R8 rx flush", rx_out_valid, 0);
    for (int i = 0; i < 13; i++) rx_push(8'(i + 16));
    chk("R3 16 code3 at 13", irq_rx_thr, 0);
    rx_push(8'd29);
    chk("R3 16 code3 at 14", irq_rx_thr, 1);
    rx_push(8'd30); rx_push(8'd31);
    chk("R2 16 full ready low", rx_in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      rx_pop(d);
      chk("R9 order", d, i + 16);
    end
    chk("R4 code3 below after reads", irq_rx_thr, 0);
    cfg(8'b0000_0011); cyc(1);
  endtask

  task automatic t_rx32;
    cfg(8'b1000_1011); cyc(1);
    for (int i = 0; i < 15; i++) rx_push(8'(i));
    chk("R3 32 code2 at 15", irq_rx_thr, 0);
    rx_push(8'd15);
    chk("R3 32 code2 at 16", irq_rx_thr, 1);
    cfg(8'b1100_1001);
    chk("R3 32 code3 at 16", irq_rx_thr, 0);
    for (int i = 0; i < 9; i++) rx_push(8'(i));
    chk("R3 32 code3 at 25", irq_rx_thr, 0);
    rx_push(8'd9);
    chk("R3 32 code3 at 26", irq_rx_thr, 1);
    for (int i = 0; i < 6; i++) rx_push(8'(i));
    chk("R2 32 full ready low", rx_in_ready, 0);
    cfg(8'b1100_1011); cyc(1);
    chk("R8 rx flush 32", rx_out_valid, 0);
    rx_push(8'h5A); cyc(3);
    chk("R8 flush self-clears", rx_out_valid, 1);
    cfg(8'b0100_0011); cyc(1);
  endtask

  task automatic t_timeout;
    logic [7:0] d;
    rx_push(8'h11); rx_push(8'h22);
    tick(39);
    chk("R5 one tick short", irq_rx_thr, 0);
    tick(1);
    chk("R5 timeout fires", irq_rx_thr, 1);
    rx_pop(d);
    chk("R5 read clears timeout", irq_rx_thr, 0);
    tick(20);
    rx_push(8'h33);
    tick(39);
    chk("R5 write restarts", irq_rx_thr, 0);
    tick(1);
    chk("R5 fires after restart", irq_rx_thr, 1);
    cfg(8'b0100_0011); cyc(1);
    chk("R8 flush clears timeout", irq_rx_thr, 0);
  endtask

  task automatic t_tx;
    logic [9:0] frame;
    cfg(8'b0001_0001);
    tx_push(8'hA5); tx_push(8'h01); tx_push(8'h02); tx_push(8'h03);
    chk("R6 three below four", irq_tx_thr, 1);
    tx_push(8'h04);
    chk("R6 four not below", irq_tx_thr, 0);
    frame = {1'b1, 8'hA5, 1'b0};
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk("R10 frame bit", txd, frame[i]);
    end
    tick(1); cyc(1);
    chk("R6 next byte loaded", irq_tx_thr, 1);
    chk("R7 not empty yet", irq_tx_empty, 0);
    cfg(8'b0001_0101); cyc(1);
    chk("R8 tx flush", irq_tx_empty, 0);
    tick(11); cyc(1);
    chk("R7 empty set", irq_tx_empty, 1);
    isr_rd = 1; cyc(1); isr_rd = 0;
    chk("R7 cleared by read", irq_tx_empty, 0);
    cyc(3);
    chk("R7 stays clear", irq_tx_empty, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset;
    t_depth1;
    t_rx16;
    t_rx32;
    t_timeout;
    t_tx;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule